// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This block runs a single-item vending machine. The item costs 125 cents. The machine takes 25-, 10- and 5-cent coins, each reported as a one-cycle pulse already synchronised to the clock. It adds the value of each accepted coin to a stored credit. When the credit reaches the price, it raises a one-cycle dispense strobe. No change is given: whatever was paid beyond the price is lost when the item is dispensed.

The design has two parts. A behavioural controller issues load, clear and coin-select commands. A datapath holds the credit register, a coin-value mux, an adder and a price comparator. The controller's decisions depend on the external inputs and on the comparator's "enough credit" status. An enable input switches the machine on and off. While it is low, no coin is accepted, no dispense occurs and the stored credit is kept.

Top module: `vend_unit`

## Requirements
- R1: `rst` is synchronous and active high, and it overrides `enable` and every coin input. After a clock edge with `rst` high, the credit is 0 and `dispense` is 0, even if a coin pulse was present in that cycle.
- R2: An accepted `coin25` pulse adds 25 to the credit, `coin10` adds 10 and `coin5` adds 5.
- R3: If more than one coin input is high in the same cycle, only one value is added. `coin25` wins over `coin10`, and `coin10` wins over `coin5`.
- R4: Suppose a coin is accepted at clock edge E and brings the credit to 125 or more. Then `dispense` is low between E and E+1, high for exactly one cycle between E+1 and E+2, and low again after E+2.
- R5: At the edge that ends the dispense cycle, the credit is cleared to 0. Any excess over the price is discarded.
- R6: While `enable` is low, coin pulses are ignored and `dispense` stays low.
- R7: While `enable` is low, the stored credit is held. When `enable` returns high, collection resumes from the held value. If the held credit already meets the price, the dispense occurs one cycle after `enable` returns.
- R8: Coin pulses are discarded in two cases: while the credit is already at or above the price, and during the dispense cycle. As a result the credit never exceeds 145.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Machine on (1) / off (0) |
| coin25 | input | 1 | One-cycle pulse: 25-cent coin inserted |
| coin10 | input | 1 | One-cycle pulse: 10-cent coin inserted |
| coin5 | input | 1 | One-cycle pulse: 5-cent coin inserted |
| dispense | output | 1 | One-cycle strobe releasing the item |

## Verification
The bench aims at the cases where a credit total drifts without showing up at once. After an overshoot to 145, it must take exactly 25 nickels to reach the next dispense. A design that kept the excess would dispense early, and one that added a coin arriving during the dispense cycle or while the credit already met the price would also dispense early. Two further cases test coin priority. Simultaneous coin pulses that were summed instead of prioritised would dispense after four triple pulses rather than five. A dime and nickel given together that were summed would dispense before the twelfth pair. Separate tests drop `enable` exactly when the price is reached and apply `rst` together with a coin. A design that dispensed while off, counted coins while off, lost the held credit, or let the coin through on reset would miss the expected dispense cycle.

// File: rtl/vend_pkg.sv
package vend_pkg;

    localparam int CREDIT_W   = 8;
    localparam int PRICE_CTS  = 125;
    localparam int VAL_BIG    = 25;
    localparam int VAL_MID    = 10;
    localparam int VAL_SMALL  = 5;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_BIG   = 2'd1,
        SEL_MID   = 2'd2,
        SEL_SMALL = 2'd3
    } coin_sel_e;

    typedef enum logic {
        ST_COLLECT = 1'b0,
        ST_VEND    = 1'b1
    } vend_state_e;

    typedef struct packed {
        logic      load;
        logic      clear;
        coin_sel_e sel;
    } dp_cmd_t;

    // Fixed priority: largest coin first, one coin per cycle.
    function automatic coin_sel_e pick_coin(input logic c25, input logic c10,
                                            input logic c5);
        if (c25)      return SEL_BIG;
        else if (c10) return SEL_MID;
        else if (c5)  return SEL_SMALL;
        else          return SEL_NONE;
    endfunction

endpackage

// File: rtl/vend_datapath.sv
module vend_datapath
    import vend_pkg::*;
#(
    parameter int W      = CREDIT_W,
    parameter int PRICE  = PRICE_CTS,
    parameter int V_BIG  = VAL_BIG,
    parameter int V_MID  = VAL_MID,
    parameter int V_SML  = VAL_SMALL
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    enable,
    input  dp_cmd_t cmd,
    output logic    enough
);
    localparam int MAX_CREDIT = PRICE - V_SML + V_BIG;
    localparam logic [W-1:0] PRICE_W = W'(PRICE);

    logic [W-1:0] credit_q;
    logic [W-1:0] coin_val;
    logic [W-1:0] sum;

    // Input-select mux
    always_comb begin
        case (cmd.sel)
            SEL_BIG:   coin_val = W'(V_BIG);
            SEL_MID:   coin_val = W'(V_MID);
            SEL_SMALL: coin_val = W'(V_SML);
            default:   coin_val = '0;
        endcase
    end

    // Adder
    assign sum = credit_q + coin_val;

    // Credit register
    always_ff @(posedge clk) begin
        if (rst || cmd.clear)
            credit_q <= '0;
        else if (cmd.load)
            credit_q <= sum;
    end

    // Comparator
    assign enough = (credit_q >= PRICE_W);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (credit_q == '0));

    a_r5_clear_empties: assert property (@(posedge clk) disable iff (rst)
        cmd.clear |=> (credit_q == '0));

    a_r7_off_holds: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (credit_q == $past(credit_q)));

    a_r8_credit_bound: assert property (@(posedge clk) disable iff (rst)
        credit_q <= W'(MAX_CREDIT));

endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
    import vend_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    enable,
    input  logic    coin25,
    input  logic    coin10,
    input  logic    coin5,
    input  logic    enough,
    output dp_cmd_t cmd,
    output logic    dispense
);
    vend_state_e state_q, state_d;
    coin_sel_e   req_sel;

    assign req_sel = pick_coin(coin25, coin10, coin5);

    always_comb begin
        state_d   = state_q;
        cmd.load  = 1'b0;
        cmd.clear = 1'b0;
        cmd.sel   = SEL_NONE;
        case (state_q)
            ST_COLLECT: begin
                if (enable) begin
                    if (enough) begin
                        state_d = ST_VEND;
                    end else if (req_sel != SEL_NONE) begin
                        cmd.load = 1'b1;
                        cmd.sel  = req_sel;
                    end
                end
            end
            ST_VEND: begin
                state_d   = ST_COLLECT;
                cmd.clear = enable;
            end
            default: state_d = ST_COLLECT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_COLLECT;
        else     state_q <= state_d;
    end

    assign dispense = (state_q == ST_VEND) && enable;

    a_r4_vend_needs_credit: assert property (@(posedge clk) disable iff (rst)
        $rose(dispense) |-> $past(enough));

    a_r6_off_no_load: assert property (@(posedge clk) disable iff (rst)
        !enable |-> (!cmd.load && !cmd.clear));

    a_r3_single_select: assert property (@(posedge clk) disable iff (rst)
        (cmd.load && coin25) |-> (cmd.sel == SEL_BIG));

endmodule

// File: rtl/vend_unit.sv
module vend_unit
    import vend_pkg::*;
#(
    parameter int W     = CREDIT_W,
    parameter int PRICE = PRICE_CTS
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic coin25,
    input  logic coin10,
    input  logic coin5,
    output logic dispense
);
    dp_cmd_t cmd;
    logic    enough;

    vend_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .coin25   (coin25),
        .coin10   (coin10),
        .coin5    (coin5),
        .enough   (enough),
        .cmd      (cmd),
        .dispense (dispense)
    );

    vend_datapath #(
        .W     (W),
        .PRICE (PRICE)
    ) u_dp (
        .clk    (clk),
        .rst    (rst),
        .enable (enable),
        .cmd    (cmd),
        .enough (enough)
    );

    a_r6_off_no_dispense: assert property (@(posedge clk) disable iff (rst)
        !enable |-> !dispense);

    a_r4_one_cycle: assert property (@(posedge clk) disable iff (rst)
        dispense |=> !dispense);

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> !dispense);

endmodule

// File: tb/vend_unit_bench.sv
`timescale 1ns/1ps
module vend_unit_bench;
    logic clk = 1'b0;
    logic rst, enable, coin25, coin10, coin5;
    logic dispense;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    vend_unit u_vend_unit (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .coin25   (coin25),
        .coin10   (coin10),
        .coin5    (coin5),
        .dispense (dispense)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input logic exp, input string tag);
        checks++;
        if (dispense !== exp) begin
            errors++;
            $display("FAIL %s: dispense=%b expected=%b at %0t", tag, dispense, exp, $time);
        end
    endtask

    // Drive one cycle of coin pulses; returns at the negedge after the edge.
    task automatic coin(input logic q, input logic d, input logic n);
        coin25 = q; coin10 = d; coin5 = n;
        step();
        coin25 = 1'b0; coin10 = 1'b0; coin5 = 1'b0;
    endtask

    // Called right after the coin that reaches the price (R4 timing).
    task automatic expect_vend(input string tag);
        chk(1'b0, {tag, " R4 pre"});
        step();
        chk(1'b1, {tag, " R4 strobe"});
        step();
        chk(1'b0, {tag, " R4 post"});
    endtask

    task automatic quarters_no_vend(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            coin(1'b1, 1'b0, 1'b0);
            chk(1'b0, tag);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step();
        chk(1'b0, "R1 reset state");
        rst = 1'b0;
    endtask

    task automatic t_r2_mixed();
        quarters_no_vend(4, "R2 100");
        coin(1'b0, 1'b1, 1'b0); chk(1'b0, "R2 110");
        coin(1'b0, 1'b0, 1'b1); chk(1'b0, "R2 115");
        coin(1'b0, 1'b1, 1'b0);
        expect_vend("R2 mixed 125");
    endtask

    task automatic t_r5_overshoot();
        for (int i = 0; i < 12; i++) begin
            coin(1'b0, 1'b1, 1'b0);
            chk(1'b0, "R2 dimes below price");
        end
        coin(1'b1, 1'b0, 1'b0);
        expect_vend("R5 overshoot 145");
        for (int i = 0; i < 24; i++) begin
            coin(1'b0, 1'b0, 1'b1);
            chk(1'b0, "R5 excess discarded");
        end
        coin(1'b0, 1'b0, 1'b1);
        expect_vend("R5 nickels 125");
    endtask

    task automatic t_r3_priority();
        for (int i = 0; i < 4; i++) begin
            coin(1'b1, 1'b1, 1'b1);
            chk(1'b0, "R3 triple adds 25 only");
        end
        coin(1'b1, 1'b1, 1'b1);
        expect_vend("R3 triple x5");
        for (int i = 0; i < 12; i++) begin
            coin(1'b0, 1'b1, 1'b1);
            chk(1'b0, "R3 dime beats nickel");
        end
        coin(1'b0, 1'b0, 1'b1);
        expect_vend("R3 pairs then nickel");
    endtask

    task automatic t_r8_late_coins();
        quarters_no_vend(4, "R8 build");
        coin(1'b1, 1'b0, 1'b0);      // reaches 125
        chk(1'b0, "R8 R4 pre");
        coin(1'b1, 1'b0, 1'b0);      // presented while credit meets price
        chk(1'b1, "R8 R4 strobe");
        coin(1'b1, 1'b0, 1'b0);      // presented during dispense cycle
        chk(1'b0, "R8 R4 post");
        quarters_no_vend(4, "R8 late coins discarded");
        coin(1'b1, 1'b0, 1'b0);
        expect_vend("R8 next sale");
    endtask

    task automatic t_r6_r7_off();
        quarters_no_vend(4, "R7 build 100");
        enable = 1'b0;
        for (int i = 0; i < 3; i++) begin
            coin(1'b1, 1'b0, 1'b0);
            chk(1'b0, "R6 coin ignored while off");
        end
        step(); step();
        enable = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step();
            chk(1'b0, "R6 off coins not credited");
        end
        coin(1'b1, 1'b0, 1'b0);
        expect_vend("R7 held credit resumes");
    endtask

    task automatic t_r6_off_at_price();
        quarters_no_vend(4, "R6 build");
        coin(1'b1, 1'b0, 1'b0);
        enable = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk(1'b0, "R6 no dispense while off");
            step();
        end
        enable = 1'b1;
        chk(1'b0, "R7 pre resume");
        step();
        chk(1'b1, "R7 dispense after resume");
        step();
        chk(1'b0, "R4 single cycle after resume");
        quarters_no_vend(4, "R5 cleared after resume sale");
        coin(1'b1, 1'b0, 1'b0);
        expect_vend("R7 next sale");
    endtask

    task automatic t_r1_reset_mid();
        quarters_no_vend(4, "R1 build");
        rst = 1'b1; coin25 = 1'b1;
        step();
        rst = 1'b0; coin25 = 1'b0;
        chk(1'b0, "R1 reset with coin");
        quarters_no_vend(4, "R1 credit cleared");
        coin(1'b1, 1'b0, 1'b0);
        expect_vend("R1 after reset");
        quarters_no_vend(4, "R1 build2");
        coin(1'b1, 1'b0, 1'b0);
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk(1'b0, "R1 reset at price");
        step();
        chk(1'b0, "R1 no dispense after reset");
        quarters_no_vend(4, "R1 cleared at price");
        coin(1'b1, 1'b0, 1'b0);
        expect_vend("R1 sale after reset");
    endtask

    initial begin
        rst = 1'b1; enable = 1'b1;
        coin25 = 1'b0; coin10 = 1'b0; coin5 = 1'b0;
        step(); step();
        do_reset();
        t_r2_mixed();
        t_r5_overshoot();
        t_r3_priority();
        t_r8_late_coins();
        t_r6_r7_off();
        t_r6_off_at_price();
        t_r1_reset_mid();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule